// File: doc/BRIEF.md
# Instruction Fetch Breakpoint Unit

This block is a set of debug breakpoint channels that watch a processor's stream of executed instructions. Each channel holds a match address and a small mode word. When an instruction that really executes starts at the programmed address, the channel raises a break request toward the interrupt logic. A break is never raised by an instruction that was fetched and then thrown away. Each channel chooses whether the break lands before or after the matched instruction. The instruction stream arrives as one retire event per instruction. The event carries the instruction's start address and flags for squashed, delay-slot, delayed-branch and interrupt-blocking instructions.

The interrupt logic cannot take a request at every instruction boundary. A boundary is closed when the instruction after it sits in a delay slot, or when the instruction before it blocks interrupts. A break that would fall on a closed boundary is held in a per-channel pending flag. It is delivered at the next executed instruction whose leading boundary is open. A delivered break stays asserted until the interrupt logic acknowledges it. A per-channel sticky hit flag records the delivery until software writes 1 to clear it.

Top module: `bkpt_unit`

## Requirements
- R1: After reset `brk_req` is 0, `hit_sticky` is all zeros, and every channel is disabled.
- R2: For a channel with `en=1`, `fetch=1`, `post=0` whose address matches an executed instruction at an open leading boundary, `brk_req` is 1 in the cycle after that instruction's retire event.
- R3: For a channel with `post=1`, a match on an executed instruction that is neither a delayed branch (`ex_dbranch=0`) nor interrupt-blocking (`ex_inhib=0`) sets `brk_req` in the cycle after the retire event.
- R4: A retire event with `ex_kill=1` never raises a break. It also never releases a pending one. Pending state changes only on executed instructions, on disable and on reset.
- R5: A pre-execution match is deferred when its leading boundary is closed. That happens when `ex_dslot=1`, or when the previous executed instruction had `ex_inhib=1`. The break is delivered after the next executed instruction whose leading boundary is open.
- R6: A post-execution match on an instruction with `ex_dbranch=1` or `ex_inhib=1` is deferred. The break is delivered after the next executed instruction whose leading boundary is open.
- R7: Address comparison ignores bit 0 of both addresses and compares every other bit. A channel programmed with the second halfword of a 32-bit instruction (start + 2) does not fire when that instruction executes.
- R8: A channel whose `fetch` mode bit is 0 never raises a break, whatever the address.
- R9: `brk_req` stays 1 until `brk_ack=1` is sampled. It is 0 in the following cycle unless a new break is delivered in that same cycle.
- R10: A channel with `en=0` raises no break. Its pending flag and its outstanding request clear at the first clock edge at which the disable is in effect.
- R11: `hit_sticky[i]` goes to 1 on every break delivered by channel i. It clears when `stat_clr[i]=1`. A delivery in the same cycle as the clear wins.
- R12: `brk_req` is the OR of all channels' outstanding requests. Several channels may hit the same instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write the channel selected by `cfg_sel` |
| cfg_sel | input | CHW | Channel index for a configuration write |
| cfg_en | input | 1 | Channel enable written |
| cfg_fetch | input | 1 | Select instruction execution as the break condition |
| cfg_post | input | 1 | 1 = break after the instruction, 0 = before it |
| cfg_addr | input | AW | Match address written (bit 0 ignored) |
| ex_valid | input | 1 | Retire event for one instruction |
| ex_kill | input | 1 | The instruction was discarded and not executed |
| ex_dslot | input | 1 | The instruction sits in a branch delay slot |
| ex_dbranch | input | 1 | The instruction is a delayed branch |
| ex_inhib | input | 1 | The instruction blocks interrupts at the boundary after it |
| ex_addr | input | AW | Start address of the instruction |
| brk_ack | input | 1 | The interrupt logic takes the outstanding break |
| stat_clr | input | NCH | Write-1-to-clear for the sticky hit flags |
| brk_req | output | 1 | Break request to the interrupt logic |
| hit_sticky | output | NCH | Per-channel sticky hit flags |

## Verification
The assertions assume that each retire event lasts exactly one cycle per instruction. They also assume that `ex_dslot` is only ever raised on the instruction that follows a delayed branch, and that `brk_ack` is meaningful only while `brk_req` is high. The stimulus follows these rules: every instruction is one retire cycle followed by a check, delay-slot flags appear only right after a delayed branch, and acknowledges are issued only while a break is outstanding. Configuration writes are made between instructions, never in the same cycle as a retire event.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  // One retire event from the execute stage
  typedef struct packed {
    logic valid;    // an instruction reached retire this cycle
    logic kill;     // it was discarded, not executed
    logic dslot;    // it sits in a delay slot
    logic dbranch;  // it is a delayed branch
    logic inhib;    // it blocks interrupts at the boundary after it
  } ex_flags_t;

  // Per-channel mode word
  typedef struct packed {
    logic en;
    logic fetch;
    logic post;
  } chan_mode_t;

endpackage

// File: rtl/bkpt_cfg_bank.sv
module bkpt_cfg_bank
  import bkpt_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [CHW-1:0]            sel,
  input  chan_mode_t                wr_mode,
  input  logic [AW-1:0]             wr_addr,
  output chan_mode_t [NCH-1:0]      mode_o,
  output logic [NCH-1:0][AW-1:0]    addr_o
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_o[i] <= '0;
        addr_o[i] <= '0;
      end else if (we && (sel == CHW'(i))) begin
        mode_o[i] <= wr_mode;
        addr_o[i] <= wr_addr;
      end
    end

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
      (we && (sel == CHW'(i))) |=> (mode_o[i] == $past(wr_mode))); // R10
  end

endmodule

// File: rtl/bkpt_boundary.sv
module bkpt_boundary
  import bkpt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ex_flags_t ev,
  output logic      exec,         // instruction really executes
  output logic      open_before,  // boundary in front of it takes interrupts
  output logic      open_after    // boundary after it takes interrupts
);

  logic last_inhib;

  assign exec        = ev.valid && !ev.kill;
  assign open_before = exec && !ev.dslot && !last_inhib;
  assign open_after  = exec && !ev.dbranch && !ev.inhib;

  always_ff @(posedge clk) begin
    if (rst)       last_inhib <= 1'b0;
    else if (exec) last_inhib <= ev.inhib;
  end

  AST_INHIB_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (exec && ev.inhib) |=> !open_before); // R5
  AST_KILL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (ev.valid && ev.kill) |=> $stable(last_inhib)); // R4

endmodule

// File: rtl/bkpt_chan.sv
module bkpt_chan
  import bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  chan_mode_t    mode,
  input  logic [AW-1:0] match_addr,
  input  logic [AW-1:0] ex_addr,
  input  logic          exec,
  input  logic          open_before,
  input  logic          open_after,
  input  logic          ack,
  input  logic          clr,
  output logic          req,
  output logic          sticky,
  output logic          deliver
);

  localparam logic [AW-1:0] CMP_MASK = ~AW'(1);

  logic hit, defer, pend;

  assign hit = mode.en && mode.fetch && exec &&
               (((match_addr ^ ex_addr) & CMP_MASK) == '0);

  assign defer = hit && (mode.post ? !open_after : !open_before);

  assign deliver = mode.en && exec &&
                   ((pend && open_before) ||
                    (hit && !mode.post && open_before) ||
                    (hit &&  mode.post && open_after));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      req    <= 1'b0;
      sticky <= 1'b0;
    end else begin
      if (!mode.en) begin
        pend <= 1'b0;
        req  <= 1'b0;
      end else begin
        if (defer)        pend <= 1'b1;
        else if (deliver) pend <= 1'b0;
        req <= (req && !ack) || deliver;
      end
      sticky <= deliver || (sticky && !clr);
    end
  end

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    deliver |=> sticky); // R11
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (req && !ack && mode.en) |=> req); // R9
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (req && ack && !deliver) |=> !req); // R9
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !mode.en |=> (!req && !pend)); // R10
  AST_IDLE_PEND: assert property (@(posedge clk) disable iff (rst)
    (!exec && mode.en) |=> $stable(pend)); // R4
  AST_DELIVER_EXEC: assert property (@(posedge clk) disable iff (rst)
    deliver |-> exec); // R4

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_sel,
  input  logic            cfg_en,
  input  logic            cfg_fetch,
  input  logic            cfg_post,
  input  logic [AW-1:0]   cfg_addr,
  input  logic            ex_valid,
  input  logic            ex_kill,
  input  logic            ex_dslot,
  input  logic            ex_dbranch,
  input  logic            ex_inhib,
  input  logic [AW-1:0]   ex_addr,
  input  logic            brk_ack,
  input  logic [NCH-1:0]  stat_clr,
  output logic            brk_req,
  output logic [NCH-1:0]  hit_sticky
);

  chan_mode_t [NCH-1:0]   mode;
  logic [NCH-1:0][AW-1:0] maddr;
  logic [NCH-1:0]         req_v, dlv_v;
  chan_mode_t             wr_mode;
  ex_flags_t              ev;
  logic                   exec, open_before, open_after;

  assign wr_mode = '{en: cfg_en, fetch: cfg_fetch, post: cfg_post};
  assign ev      = '{valid: ex_valid, kill: ex_kill, dslot: ex_dslot,
                     dbranch: ex_dbranch, inhib: ex_inhib};

  bkpt_cfg_bank #(.NCH(NCH), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel),
    .wr_mode(wr_mode), .wr_addr(cfg_addr),
    .mode_o(mode), .addr_o(maddr)
  );

  bkpt_boundary u_bnd (
    .clk(clk), .rst(rst), .ev(ev),
    .exec(exec), .open_before(open_before), .open_after(open_after)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    bkpt_chan #(.AW(AW)) u_ch (
      .clk(clk), .rst(rst), .mode(mode[i]), .match_addr(maddr[i]),
      .ex_addr(ex_addr), .exec(exec), .open_before(open_before),
      .open_after(open_after), .ack(brk_ack), .clr(stat_clr[i]),
      .req(req_v[i]), .sticky(hit_sticky[i]), .deliver(dlv_v[i])
    );
  end

  assign brk_req = |req_v;

  AST_ANY_DELIVER: assert property (@(posedge clk) disable iff (rst)
    (|dlv_v) |=> brk_req); // R12
  AST_KILL_SILENT: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && ex_kill && !brk_req) |=> !brk_req); // R4

endmodule

// File: tb/bkpt_unit_tb.sv
module bkpt_unit_tb;

  localparam int NCH = 2;
  localparam int AW  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0, cfg_en = 0, cfg_fetch = 0, cfg_post = 0;
  logic [0:0] cfg_sel = '0;
  logic [AW-1:0] cfg_addr = '0, ex_addr = '0;
  logic ex_valid = 0, ex_kill = 0, ex_dslot = 0, ex_dbranch = 0, ex_inhib = 0;
  logic brk_ack = 0;
  logic [NCH-1:0] stat_clr = '0;
  logic brk_req;
  logic [NCH-1:0] hit_sticky;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bkpt_unit #(.NCH(NCH), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_en(cfg_en), .cfg_fetch(cfg_fetch), .cfg_post(cfg_post),
    .cfg_addr(cfg_addr), .ex_valid(ex_valid), .ex_kill(ex_kill),
    .ex_dslot(ex_dslot), .ex_dbranch(ex_dbranch), .ex_inhib(ex_inhib),
    .ex_addr(ex_addr), .brk_ack(brk_ack), .stat_clr(stat_clr),
    .brk_req(brk_req), .hit_sticky(hit_sticky)
  );

  // {valid, kill, dslot, dbranch, inhib, ack, expected brk_req, addr[11:0]}
  function automatic logic [18:0] mk(input logic v, k, ds, db, ih, ak, ex,
                                     input logic [11:0] a);
    return {v, k, ds, db, ih, ak, ex, a};
  endfunction

  localparam int NV = 32;
  localparam logic [18:0] VEC [NV] = '{
    mk(1,0,0,0,0,0,0,12'h0FC), mk(1,0,0,0,0,0,1,12'h100),
    mk(0,0,0,0,0,1,0,12'h000), mk(1,1,0,0,0,0,0,12'h100),
    mk(1,0,0,0,0,0,1,12'h101), mk(0,0,0,0,0,1,0,12'h000),
    mk(1,0,0,0,0,0,0,12'h1FE), mk(1,0,0,0,0,0,1,12'h200),
    mk(0,0,0,0,0,0,1,12'h000), mk(0,0,0,0,0,1,0,12'h000),
    mk(1,0,0,1,0,0,0,12'h0F0), mk(1,0,1,0,0,0,0,12'h100),
    mk(1,0,0,0,0,0,1,12'h300), mk(0,0,0,0,0,1,0,12'h000),
    mk(1,0,0,0,1,0,0,12'h0F8), mk(1,0,0,0,0,0,0,12'h100),
    mk(1,0,0,0,0,0,1,12'h104), mk(0,0,0,0,0,1,0,12'h000),
    mk(1,0,0,1,0,0,0,12'h200), mk(1,0,1,0,0,0,0,12'h204),
    mk(1,0,0,0,0,0,1,12'h208), mk(0,0,0,0,0,1,0,12'h000),
    mk(1,0,0,0,1,0,0,12'h200), mk(1,0,0,0,0,0,0,12'h204),
    mk(1,0,0,0,0,0,1,12'h208), mk(0,0,0,0,0,1,0,12'h000),
    mk(1,0,0,0,0,0,0,12'h206), mk(1,0,0,1,0,0,0,12'h0F0),
    mk(1,0,1,0,0,0,0,12'h100), mk(1,1,0,0,0,0,0,12'h300),
    mk(1,0,0,0,0,0,1,12'h304), mk(0,0,0,0,0,1,0,12'h000)
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input logic en, input logic fe, input logic po,
                     input logic [AW-1:0] a);
    cfg_we = 1; cfg_sel = ch[0:0]; cfg_en = en; cfg_fetch = fe; cfg_post = po; cfg_addr = a;
    step();
    cfg_we = 0;
  endtask

  task automatic instr(input logic k, input logic ds, input logic db, input logic ih,
                       input logic [AW-1:0] a);
    ex_valid = 1; ex_kill = k; ex_dslot = ds; ex_dbranch = db; ex_inhib = ih; ex_addr = a;
    step();
    ex_valid = 0; ex_kill = 0; ex_dslot = 0; ex_dbranch = 0; ex_inhib = 0;
  endtask

  task automatic ack();
    brk_ack = 1;
    step();
    brk_ack = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog: actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) step();
    check(32'(brk_req), 0, "R1 reset brk_req");
    check(32'(hit_sticky), 0, "R1 reset hit_sticky");
    rst = 0;
    step();
    instr(0, 0, 0, 0, 32'h100);
    check(32'(brk_req), 0, "R1 channels disabled after reset");

    cfg(0, 1, 1, 0, 32'h100);
    cfg(1, 1, 1, 1, 32'h200);

    // Table walk: covers R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      ex_valid = VEC[i][18]; ex_kill = VEC[i][17]; ex_dslot = VEC[i][16];
      ex_dbranch = VEC[i][15]; ex_inhib = VEC[i][14]; brk_ack = VEC[i][13];
      ex_addr = AW'(VEC[i][11:0]);
      step();
      check(32'(brk_req), 32'(VEC[i][12]),
            $sformatf("R2/R3/R4/R5/R6/R7/R9 table step %0d", i));
    end
    ex_valid = 0; ex_kill = 0; ex_dslot = 0; ex_dbranch = 0; ex_inhib = 0; brk_ack = 0;

    // R11 sticky and write-1-to-clear
    check(32'(hit_sticky), 32'h3, "R11 sticky after table");
    stat_clr = 2'b01; step(); stat_clr = 0;
    check(32'(hit_sticky), 32'h2, "R11 clear channel 0");
    stat_clr = 2'b10; step(); stat_clr = 0;
    check(32'(hit_sticky), 32'h0, "R11 clear channel 1");

    // R12 two channels on one instruction
    cfg(1, 1, 1, 1, 32'h100);
    instr(0, 0, 0, 0, 32'h100);
    check(32'(brk_req), 1, "R12 both channels hit");
    check(32'(hit_sticky), 32'h3, "R12 both sticky");
    ack();
    check(32'(brk_req), 0, "R9 ack after dual hit");

    // R7 second halfword and bit-0 ignore
    cfg(1, 0, 1, 1, 32'h100);
    cfg(0, 1, 1, 0, 32'h102);
    instr(0, 0, 0, 0, 32'h100);
    check(32'(brk_req), 0, "R7 second halfword of wide instruction");
    instr(0, 0, 0, 0, 32'h102);
    check(32'(brk_req), 1, "R7 start address match");
    ack();

    // R8 fetch mode bit clear
    cfg(0, 1, 0, 0, 32'h100);
    instr(0, 0, 0, 0, 32'h100);
    check(32'(brk_req), 0, "R8 fetch bit clear");

    // R10 disable drops a pending break
    cfg(0, 1, 1, 0, 32'h100);
    instr(0, 0, 1, 0, 32'h0F0);
    instr(0, 1, 0, 0, 32'h100);
    check(32'(brk_req), 0, "R5 deferred in delay slot");
    cfg(0, 0, 1, 0, 32'h100);
    cfg(0, 1, 1, 0, 32'h100);
    instr(0, 0, 0, 0, 32'h300);
    check(32'(brk_req), 0, "R10 pending cleared by disable");

    // R10 disable drops an outstanding request
    instr(0, 0, 0, 0, 32'h100);
    check(32'(brk_req), 1, "R2 request before disable");
    cfg(0, 0, 1, 0, 32'h100);
    check(32'(brk_req), 1, "R10 disable not yet in effect");
    step();
    check(32'(brk_req), 0, "R10 request cleared by disable");

    // R11 delivery beats a simultaneous clear
    cfg(0, 1, 1, 0, 32'h100);
    stat_clr = 2'b11; step(); stat_clr = 0;
    check(32'(hit_sticky), 32'h0, "R11 cleared before race");
    stat_clr = 2'b01;
    instr(0, 0, 0, 0, 32'h100);
    stat_clr = 0;
    check(32'(hit_sticky), 32'h1, "R11 set wins over clear");
    ack();
    check(32'(brk_req), 0, "R9 final ack");

    summary();
    $finish;
  end

endmodule